// File: doc/BRIEF.md
# Windowed Joint Digit Expansion Stager

This block accepts two streams of binary tau-adic digits, one per scalar, presented together as one digit pair per handshake, least significant pair first. It collects the pairs into aligned windows of `W` positions. For each window it forms a lookup address from the two collected digit groups and turns it into a short list of joint terms. Each term carries one digit per scalar, a tau exponent, and an exponent of the second base `(1 + tau)`. The tau exponent of every term is shifted by `W` times the window index before the term leaves the block.

A consumer takes the terms over a valid/ready handshake, in order of rising tau exponent. Two status levels accompany the stream. `firstReady` reports that the first window of the current stream has been captured. `endFlag` reports that the last window has been fully emitted. A stream that ends partway through a window has its missing high digits taken as zero.

Top module: `joint_window_stager`

## Requirements
- R1: After reset, `outValid`, `firstReady` and `endFlag` are 0 and `inReady` is 1.
- R2: The digit pair accepted as the j-th pair of window i sits at window position j. Every term from window i has `outTauExp` = W*i + (its position in the window). Terms leave in strictly increasing `outTauExp` within a stream.
- R3: The terms reconstruct both scalars. A term with digits (a, b), tau exponent t and `outSecExp` s adds a*(1+tau)^s*tau^t to scalar A and b*(1+tau)^s*tau^t to scalar B, with s = 1 meaning a contribution at both tau^t and tau^(t+1). No term has both digits 0. An all-zero window emits no term.
- R4: Within a window, positions are scanned from low to high. A nonzero column equal to the next column in the same window forms one term with `outSecExp` = 1 at the lower position, and both columns are consumed. Any other nonzero column forms one term with `outSecExp` = 0.
- R5: When `inLast` arrives before a window is full, the remaining positions of that window are taken as zero and that window ends the stream.
- R6: While `outValid` is 1 and `outReady` is 0, the term outputs hold steady. `inReady` is 0 whenever `outValid` is 1.
- R7: `firstReady` becomes 1 in the cycle after the edge that accepts the final pair of the first window of a stream. It returns to 0 when the first pair of the next stream is accepted.
- R8: `endFlag` becomes 1 once every term of the window closed by `inLast` has been taken. It returns to 0 when the first pair of the next stream is accepted, and that stream starts again at window 0.
- R9: `outSecExp` never exceeds 1, which stays within the small bound on the second-base exponent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A digit pair is offered |
| inReady | output | 1 | The block takes a digit pair this cycle |
| inDigA | input | 1 | Digit of scalar A (0 or 1) |
| inDigB | input | 1 | Digit of scalar B (0 or 1) |
| inLast | input | 1 | This pair is the last of the stream |
| outValid | output | 1 | A joint term is presented |
| outReady | input | 1 | The consumer takes the term |
| outDigA | output | 1 | Term digit for scalar A |
| outDigB | output | 1 | Term digit for scalar B |
| outTauExp | output | $clog2(W*MAX_BLOCKS) | Tau exponent including the window offset |
| outSecExp | output | SEC_W | Exponent of the second base (1+tau) |
| firstReady | output | 1 | First window of the stream is captured |
| endFlag | output | 1 | The last window of the stream is emitted |

## Verification
The checks assume that each stream holds at most W*MAX_BLOCKS digit pairs and that its last pair carries `inLast`. A new stream must not start until `endFlag` has been seen. The rising-exponent check also relies on `endFlag` separating streams. The stimulus keeps every stream within 24 pairs, which is the default capacity. It waits for `endFlag` before it offers the next stream, and it holds each offered pair until `inReady` takes it.

// File: rtl/jws_pkg.sv
package jws_pkg;
  typedef enum logic {ST_COLLECT, ST_EMIT} stage_e;

  typedef struct packed {
    logic accept;  // a digit pair is taken
    logic latch;   // window complete: capture lookup result
    logic pop;     // consumer takes the presented term
    logic finish;  // window drained
  } strobe_t;
endpackage

// File: rtl/jws_ctrl.sv
module jws_ctrl
  import jws_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    inValid,
  input  logic    inLast,
  input  logic    outReady,
  input  logic    winFull,
  input  logic    maskEmpty,
  output logic    inReady,
  output logic    outValid,
  output strobe_t stb
);
  stage_e state, stateNext;

  always_comb begin
    inReady    = (state == ST_COLLECT);
    outValid   = (state == ST_EMIT) && !maskEmpty;
    stb.accept = inReady && inValid;
    stb.latch  = stb.accept && (winFull || inLast);
    stb.pop    = outValid && outReady;
    stb.finish = (state == ST_EMIT) && maskEmpty;
    stateNext  = state;
    if (stb.latch)  stateNext = ST_EMIT;
    if (stb.finish) stateNext = ST_COLLECT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_COLLECT;
    else        state <= stateNext;
  end
endmodule

// File: rtl/jws_datapath.sv
module jws_datapath
  import jws_pkg::*;
#(
  parameter int W          = 3,
  parameter int MAX_BLOCKS = 8,
  parameter int SEC_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          stb,
  input  logic             inDigA,
  input  logic             inDigB,
  input  logic             inLast,
  output logic             winFull,
  output logic             maskEmpty,
  output logic             outDigA,
  output logic             outDigB,
  output logic [$clog2(W*MAX_BLOCKS)-1:0] outTauExp,
  output logic [SEC_W-1:0] outSecExp,
  output logic             firstReady,
  output logic             endFlag
);
  localparam int LW     = $clog2(W);
  localparam int BW     = $clog2(MAX_BLOCKS);
  localparam int TW     = $clog2(W*MAX_BLOCKS);
  localparam int TERM_W = LW + 3;
  localparam int ENT_W  = W + W*TERM_W;

  // Window lookup: slot k = {digA, digB, position, pairFlag}; mask marks used slots.
  function automatic logic [ENT_W-1:0] lookup(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0]        m;
    logic [W*TERM_W-1:0] t;
    logic [W:0]          ax, bx;
    logic                skip, pair;
    int                  k;
    m = '0; t = '0; k = 0; skip = 1'b0; pair = 1'b0;
    ax = {1'b0, a};
    bx = {1'b0, b};
    for (int j = 0; j < W; j++) begin
      if (skip) begin
        skip = 1'b0;
      end else if (ax[j] || bx[j]) begin
        pair = (j < W-1) && (ax[j+1] == ax[j]) && (bx[j+1] == bx[j]);
        t[k*TERM_W +: TERM_W] = {ax[j], bx[j], LW'(j), pair};
        m[k] = 1'b1;
        k    = k + 1;
        skip = pair;
      end
    end
    return {m, t};
  endfunction

  logic [W-1:0]        colA, colB, newA, newB;
  logic [LW-1:0]       cnt;
  logic [BW-1:0]       blkIdx;
  logic [W-1:0]        entMask;
  logic [W*TERM_W-1:0] entTerms;
  logic                lastBlkQ;
  logic [LW-1:0]       sel;
  logic [TERM_W-1:0]   selTerm;
  logic                streamStart;

  always_comb begin
    newA        = colA | (W'(inDigA) << cnt);
    newB        = colB | (W'(inDigB) << cnt);
    winFull     = (cnt == LW'(W-1));
    maskEmpty   = (entMask == '0);
    streamStart = stb.accept && (cnt == '0) && (blkIdx == '0);
    sel = '0;
    for (int j = W-1; j >= 0; j--) begin
      if (entMask[j]) sel = LW'(j);
    end
    selTerm   = entTerms[sel*TERM_W +: TERM_W];
    outDigA   = selTerm[TERM_W-1];
    outDigB   = selTerm[TERM_W-2];
    outTauExp = TW'(blkIdx) * TW'(W) + TW'(selTerm[LW:1]);
    outSecExp = SEC_W'(selTerm[0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      colA <= '0; colB <= '0; cnt <= '0; blkIdx <= '0;
      entMask <= '0; entTerms <= '0; lastBlkQ <= 1'b0;
      firstReady <= 1'b0; endFlag <= 1'b0;
    end else begin
      if (streamStart) begin
        firstReady <= 1'b0;
        endFlag    <= 1'b0;
      end
      if (stb.accept) begin
        if (stb.latch) begin
          colA <= '0; colB <= '0; cnt <= '0;
          {entMask, entTerms} <= lookup(newA, newB);
          lastBlkQ <= inLast;
          if (blkIdx == '0) firstReady <= 1'b1;
        end else begin
          colA <= newA; colB <= newB;
          cnt  <= cnt + 1'b1;
        end
      end
      if (stb.pop) entMask[sel] <= 1'b0;
      if (stb.finish) begin
        if (lastBlkQ) begin
          blkIdx  <= '0;
          endFlag <= 1'b1;
        end else begin
          blkIdx <= blkIdx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/joint_window_stager.sv
module joint_window_stager
  import jws_pkg::*;
#(
  parameter int W          = 3,
  parameter int MAX_BLOCKS = 8,
  parameter int SEC_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  output logic             inReady,
  input  logic             inDigA,
  input  logic             inDigB,
  input  logic             inLast,
  output logic             outValid,
  input  logic             outReady,
  output logic             outDigA,
  output logic             outDigB,
  output logic [$clog2(W*MAX_BLOCKS)-1:0] outTauExp,
  output logic [SEC_W-1:0] outSecExp,
  output logic             firstReady,
  output logic             endFlag
);
  strobe_t stb;
  logic    winFull, maskEmpty;

  jws_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inLast(inLast),
    .outReady(outReady), .winFull(winFull), .maskEmpty(maskEmpty),
    .inReady(inReady), .outValid(outValid), .stb(stb)
  );

  jws_datapath #(.W(W), .MAX_BLOCKS(MAX_BLOCKS), .SEC_W(SEC_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .inDigA(inDigA), .inDigB(inDigB),
    .inLast(inLast), .winFull(winFull), .maskEmpty(maskEmpty),
    .outDigA(outDigA), .outDigB(outDigB), .outTauExp(outTauExp),
    .outSecExp(outSecExp), .firstReady(firstReady), .endFlag(endFlag)
  );
endmodule

// File: rtl/joint_window_stager_chk.sv
module joint_window_stager_chk #(
  parameter int W          = 3,
  parameter int MAX_BLOCKS = 8,
  parameter int SEC_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic             outDigA,
  input logic             outDigB,
  input logic [$clog2(W*MAX_BLOCKS)-1:0] outTauExp,
  input logic [SEC_W-1:0] outSecExp,
  input logic             endFlag
);
  logic                                prevValid;
  logic [$clog2(W*MAX_BLOCKS)-1:0]     prevExp;

  always_ff @(posedge clk) begin
    if (!rst_n || endFlag) begin
      prevValid <= 1'b0;
      prevExp   <= '0;
    end else if (outValid && outReady) begin
      prevValid <= 1'b1;
      prevExp   <= outTauExp;
    end
  end

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(outTauExp) && $stable(outDigA)
      && $stable(outDigB) && $stable(outSecExp));

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(inReady && outValid));

  a_r3_nonzero_term: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outDigA || outDigB));

  a_r9_sec_bound: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outSecExp <= SEC_W'(1)));

  a_r2_rising_exp: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && prevValid |-> outTauExp > prevExp);

  a_r8_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(endFlag) |-> inReady && !outValid);
endmodule

bind joint_window_stager joint_window_stager_chk #(.W(W), .MAX_BLOCKS(MAX_BLOCKS), .SEC_W(SEC_W)) u_chk (.*);

// File: tb/joint_window_stager_tb.sv
module joint_window_stager_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 3;
  localparam int MAXB       = 8;
  localparam int SEC_W      = 3;
  localparam int TW         = $clog2(W*MAXB);
  localparam int NV         = 8;
  // {len[52:48], digitsA[47:24], digitsB[23:0]}, digit j at bit j
  localparam logic [52:0] VEC [NV] = '{
    {5'd24, 24'hA5C3F1, 24'h3C0FF0},
    {5'd3,  24'h000003, 24'h000003},
    {5'd7,  24'h00005B, 24'h000026},
    {5'd6,  24'h000000, 24'h000000},
    {5'd24, 24'hFFFFFF, 24'hFFFFFF},
    {5'd1,  24'h000001, 24'h000000},
    {5'd12, 24'h000F0F, 24'h0000F0},
    {5'd9,  24'h0001AB, 24'h0000D4}
  };

  logic clk = 0, rst_n = 0;
  logic inValid = 0, inDigA = 0, inDigB = 0, inLast = 0, outReady = 1;
  logic inReady, outValid, outDigA, outDigB, firstReady, endFlag;
  logic [TW-1:0] outTauExp;
  logic [SEC_W-1:0] outSecExp;

  joint_window_stager #(.W(W), .MAX_BLOCKS(MAXB), .SEC_W(SEC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inDigA(inDigA), .inDigB(inDigB), .inLast(inLast), .outValid(outValid),
    .outReady(outReady), .outDigA(outDigA), .outDigB(outDigB),
    .outTauExp(outTauExp), .outSecExp(outSecExp), .firstReady(firstReady),
    .endFlag(endFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  logic holdReady = 0, stallOn = 0;
  logic [7:0] lfsr = 8'h5A;

  int recN = 0;
  int recP [32];   // packed {a,b,t,s}
  int expN;
  int expP [32];

  function automatic int packTerm(int a, int b, int t, int s);
    return (a << 12) | (b << 11) | (t << 3) | s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    outReady = holdReady ? 1'b0 : (stallOn ? lfsr[0] : 1'b1);
  end

  always @(negedge clk) begin
    if (rst_n && outValid && outReady && recN < 32) begin
      recP[recN] = packTerm(int'(outDigA), int'(outDigB), int'(outTauExp), int'(outSecExp));
      recN++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Expected terms from R2/R4/R5: window scan, equal adjacent nonzero columns pair up.
  task automatic buildExp(input int len, input logic [23:0] a, input logic [23:0] b);
    logic [24:0] ax, bx;
    int nwin, p;
    logic skip, pr;
    ax = {1'b0, a}; bx = {1'b0, b};
    expN = 0;
    nwin = (len + W - 1) / W;
    for (int i = 0; i < nwin; i++) begin
      skip = 0;
      for (int j = 0; j < W; j++) begin
        p = i*W + j;
        if (skip) skip = 0;
        else if (ax[p] || bx[p]) begin
          pr = (j < W-1) && (ax[p+1] == ax[p]) && (bx[p+1] == bx[p]);
          expP[expN] = packTerm(int'(ax[p]), int'(bx[p]), p, int'(pr));
          expN++;
          skip = pr;
        end
      end
    end
  endtask

  task automatic checkTerms(input int len, input logic [23:0] a, input logic [23:0] b, input string req);
    logic [25:0] ra, rb;
    int t, s;
    buildExp(len, a, b);
    check(recN == expN, req, recN, expN);
    for (int k = 0; k < expN && k < recN; k++)
      check(recP[k] == expP[k], "R2 R4 term", recP[k], expP[k]);
    ra = '0; rb = '0;
    for (int k = 0; k < recN; k++) begin
      t = (recP[k] >> 3) & 8'hFF;
      s = recP[k] & 7;
      if ((recP[k] >> 12) & 1) begin ra = ra + (26'd1 << t); if (s == 1) ra = ra + (26'd1 << (t+1)); end
      if ((recP[k] >> 11) & 1) begin rb = rb + (26'd1 << t); if (s == 1) rb = rb + (26'd1 << (t+1)); end
    end
    check(ra == {2'b0, a}, "R3 rebuild A", int'(ra), int'(a));
    check(rb == {2'b0, b}, "R3 rebuild B", int'(rb), int'(b));
  endtask

  task automatic sendDigit(input logic da, input logic db, input logic last);
    inValid = 1; inDigA = da; inDigB = db; inLast = last;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    @(posedge clk); #1;
    inValid = 0; inLast = 0;
  endtask

  task automatic waitEnd();
    int n = 0;
    @(negedge clk);
    while (!endFlag && n < 2000) begin @(negedge clk); n++; end
    check(endFlag == 1'b1, "R8 end flag", int'(endFlag), 1);
    check(inReady == 1'b1 && outValid == 1'b0, "R8 idle at end", int'(outValid), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(outValid == 0, "R1 outValid", int'(outValid), 0);
    check(inReady == 1, "R1 inReady", int'(inReady), 1);
    check(firstReady == 0, "R1 firstReady", int'(firstReady), 0);
    check(endFlag == 0, "R1 endFlag", int'(endFlag), 0);
    rst_n = 1;
    @(posedge clk); #1;

    for (int v = 0; v < NV; v++) begin
      int len;
      logic [23:0] a, b;
      len = int'(VEC[v][52:48]);
      a = VEC[v][47:24];
      b = VEC[v][23:0];
      stallOn = v[0];
      recN = 0;
      for (int j = 0; j < len; j++) sendDigit(a[j], b[j], j == len-1);
      waitEnd();
      checkTerms(len, a, b, (len % W != 0) ? "R5 count" : "R2 count");
      @(posedge clk); #1;
    end

    // Directed: stream start clears flags, first window timing, hold under backpressure
    stallOn = 0;
    @(negedge clk); holdReady = 1;
    @(posedge clk); #1;
    recN = 0;
    sendDigit(1, 0, 0);
    @(negedge clk);
    check(endFlag == 0, "R8 cleared on new stream", int'(endFlag), 0);
    check(firstReady == 0, "R7 cleared on new stream", int'(firstReady), 0);
    @(posedge clk); #1;
    sendDigit(0, 1, 0);
    @(negedge clk);
    check(firstReady == 0, "R7 not before window full", int'(firstReady), 0);
    @(posedge clk); #1;
    sendDigit(1, 1, 0);
    @(negedge clk);
    check(firstReady == 1, "R7 first window captured", int'(firstReady), 1);
    check(outValid == 1 && inReady == 0, "R6 emitting blocks input", int'(inReady), 0);
    repeat (3) @(negedge clk);
    check(outValid == 1, "R6 valid held", int'(outValid), 1);
    check(outTauExp == 0 && outDigA == 1 && outDigB == 0, "R6 term held", int'(outTauExp), 0);
    holdReady = 0;
    @(posedge clk); #1;
    sendDigit(1, 1, 0);
    sendDigit(0, 0, 0);
    sendDigit(0, 0, 1);
    waitEnd();
    checkTerms(6, 24'h00000D, 24'h00000E, "R2 directed count");

    // Next stream restarts at window 0 (R8)
    @(posedge clk); #1;
    recN = 0;
    sendDigit(0, 1, 1);
    waitEnd();
    checkTerms(1, 24'h000000, 24'h000001, "R8 restart at window 0");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule